// File: doc/BRIEF.md
# Polymorphic Element-Width SIMD Adder

This block adds two 64-bit register values as a set of independent lanes. The lane width is not fixed. A 2-bit override picks the width relative to a run-time default. The default is the current base register width, which is 64 bits, or 32 bits when the narrow mode is selected. The override can keep the default, halve it, double it, or force 8-bit lanes. A doubled width is limited to 64 bits, the size of the register.

In vector mode, each lane acts as a separate small register. A hidden predicate marks the lowest `vl` lanes as active. Active lanes take their sum. Every other lane returns the bits of the old destination value, which is why the old destination is an input. In scalar mode only the lowest lane is computed. Its sum is sign- or zero-extended and replaces the whole 64-bit register.

The result is registered. It appears, with a one-cycle valid pulse, on the clock edge after a strobe on `inValid`.

Top module: `simd_elw_adder`

## Requirements
- R1: The lane width comes from `widthSel` and `narrowXlen`. The default width is 64 when `narrowXlen`=0 and 32 when it is 1. `widthSel` 2'b00 keeps the default, 2'b01 halves it, 2'b10 doubles it (limited to 64), and 2'b11 selects 8 bits. The resulting widths are 64/32/64/8 bits for `narrowXlen`=0 and 32/16/64/8 bits for `narrowXlen`=1.
- R2: Every lane wraps modulo 2^width. No carry crosses from one lane into the next.
- R3: In vector mode (`scalarOp`=0), lane i is active exactly when i < `vl`, with lane 0 in the least significant bits. When `vl` is at least the number of lanes (64/width), every lane is active. An active lane holds the sum of its `rs1` and `rs2` bits.
- R4: In vector mode, every bit of an inactive lane equals the matching bit of `rdOld`. With `vl`=0 the result equals `rdOld`.
- R5: In scalar mode (`scalarOp`=1), the lowest lane's sum is extended to 64 bits. The extension copies the lane's top bit when `signExt`=1 and fills with zeros when `signExt`=0. `vl` and `rdOld` have no effect in this mode.
- R6: `outValid` is high for exactly the cycle after each cycle with `inValid`=1 and low otherwise. `rdOut` changes only on those edges and holds its value between them.
- R7: While `rstN` is low, `rdOut` is 0 and `outValid` is 0.
- R8: In scalar mode with a 64-bit width, `rdOut` is the plain 64-bit sum of `rs1` and `rs2` modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operands and controls are valid this cycle |
| widthSel | input | 2 | Element-width override (R1 encoding) |
| narrowXlen | input | 1 | 1 selects the 32-bit default width |
| scalarOp | input | 1 | 1 for scalar mode, 0 for vector mode |
| signExt | input | 1 | Scalar extension: 1 sign, 0 zero |
| vl | input | VL_W | Vector length (number of active lanes) |
| rs1 | input | 64 | First operand register |
| rs2 | input | 64 | Second operand register |
| rdOld | input | 64 | Current destination value |
| outValid | output | 1 | Result valid pulse |
| rdOut | output | 64 | New destination value |

## Verification
A vector table covers the following patterns:
- Lanes holding all-ones plus one, which tells apart true lane isolation from a carry leaking upward.
- Old-destination patterns with alternating bits, which show which bytes were preserved and which were written.
- Vector lengths of zero, inside the lane count and beyond it, which separate the predicate edges.
- Scalar operands whose low lane has its top bit set, with garbage in the upper bits, which tell sign extension from zero extension and from no extension.

A sweep over every override, default mode, scalar/vector mode, extension select and vector lengths 0 to 9 compares pseudo-random operands against a per-lane model. This separates each width decode from its neighbours.

// File: rtl/elw_pkg.sv
package elw_pkg;

  localparam int REG_W   = 64;
  localparam int NBYTES  = REG_W / 8;
  localparam int NCODES  = 4;

  // Element width codes: width = 8 << code
  typedef enum logic [1:0] {
    EW8  = 2'd0,
    EW16 = 2'd1,
    EW32 = 2'd2,
    EW64 = 2'd3
  } elwCode_t;

  // Width override encodings
  localparam logic [1:0] SEL_DEF  = 2'b00;
  localparam logic [1:0] SEL_HALF = 2'b01;
  localparam logic [1:0] SEL_DBL  = 2'b10;
  localparam logic [1:0] SEL_BYTE = 2'b11;

  // Strobes from control to datapath
  typedef struct packed {
    logic              load;
    elwCode_t          width;
    logic              scalar;
    logic              signExt;
    logic [NBYTES-1:0] takeNew;
  } elwStrobe_t;

  function automatic logic [REG_W-1:0] lowMaskOf(input elwCode_t code);
    case (code)
      EW8:     return 64'h0000_0000_0000_00FF;
      EW16:    return 64'h0000_0000_0000_FFFF;
      EW32:    return 64'h0000_0000_FFFF_FFFF;
      default: return '1;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] byteToBits(input logic [NBYTES-1:0] bm);
    logic [REG_W-1:0] r;
    for (int i = 0; i < NBYTES; i++) r[i*8 +: 8] = {8{bm[i]}};
    return r;
  endfunction

endpackage

// File: rtl/elw_ctrl.sv
module elw_ctrl
  import elw_pkg::*;
#(
  parameter int VL_W = 7
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [1:0]      widthSel,
  input  logic            narrowXlen,
  input  logic            scalarOp,
  input  logic            signExt,
  input  logic [VL_W-1:0] vl,
  output elwStrobe_t      strobe
);

  localparam int MAX_LANES = NBYTES;

  elwCode_t             defCode;
  elwCode_t             effCode;
  logic [3:0]           laneCount;
  logic [MAX_LANES-1:0] lanePred;
  logic [NBYTES-1:0]    takeNew;

  always_comb begin
    defCode = narrowXlen ? EW32 : EW64;
    case (widthSel)
      SEL_DEF:  effCode = defCode;
      SEL_HALF: effCode = elwCode_t'(defCode - 2'd1);
      SEL_DBL:  effCode = (defCode == EW64) ? EW64 : elwCode_t'(defCode + 2'd1);
      default:  effCode = EW8;
    endcase
    laneCount = 4'd8 >> effCode;
  end

  // Hidden predicate: lane i active when i < vl and the lane exists
  for (genvar i = 0; i < MAX_LANES; i++) begin : g_pred
    assign lanePred[i] = (4'(i) < laneCount) && (vl > VL_W'(i));
  end

  // Byte-level write enables derived from the lane each byte belongs to
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    logic [2:0] laneIdx;
    assign laneIdx    = 3'(b) >> effCode;
    assign takeNew[b] = scalarOp | lanePred[laneIdx];
  end

  assign strobe = '{load:    inValid,
                    width:   effCode,
                    scalar:  scalarOp,
                    signExt: signExt,
                    takeNew: takeNew};

  AST_PRED_PREFIX: assert property (@(posedge clk) disable iff (!rstN)
    (lanePred & (lanePred + 8'd1)) == '0); // R3

  AST_VL_ZERO_KEEPS_ALL: assert property (@(posedge clk) disable iff (!rstN)
    (!scalarOp && vl == '0) |-> takeNew == '0); // R4

  AST_LONG_VL_ALL_LANES: assert property (@(posedge clk) disable iff (!rstN)
    (!scalarOp && vl >= VL_W'(MAX_LANES)) |-> takeNew == '1); // R3

  AST_DBL_CLAMP: assert property (@(posedge clk) disable iff (!rstN)
    (widthSel == SEL_DBL) |-> effCode == EW64); // R1

endmodule

// File: rtl/elw_datapath.sv
module elw_datapath
  import elw_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  elwStrobe_t       strobe,
  input  logic [REG_W-1:0] rs1,
  input  logic [REG_W-1:0] rs2,
  input  logic [REG_W-1:0] rdOld,
  output logic             outValid,
  output logic [REG_W-1:0] rdOut
);

  logic [NCODES-1:0][REG_W-1:0] sumByCode;
  logic [REG_W-1:0]             laneSum;
  logic [REG_W-1:0]             lowMask;
  logic                         topBit;
  logic [REG_W-1:0]             scalarVal;
  logic [REG_W-1:0]             newVal;
  logic [REG_W-1:0]             nextRd;

  // One adder bank per width variant; no carry between lanes
  for (genvar k = 0; k < NCODES; k++) begin : g_width
    localparam int EW    = 8 << k;
    localparam int LANES = REG_W / EW;
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign sumByCode[k][l*EW +: EW] = rs1[l*EW +: EW] + rs2[l*EW +: EW];
    end
  end

  always_comb begin
    laneSum   = sumByCode[strobe.width];
    lowMask   = lowMaskOf(strobe.width);
    topBit    = |(laneSum & (lowMask ^ (lowMask >> 1)));
    scalarVal = (laneSum & lowMask) |
                ((strobe.signExt && topBit) ? ~lowMask : '0);
    newVal    = strobe.scalar ? scalarVal : laneSum;
    for (int b = 0; b < NBYTES; b++) begin
      nextRd[b*8 +: 8] = strobe.takeNew[b] ? newVal[b*8 +: 8] : rdOld[b*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdOut    <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= strobe.load;
      if (strobe.load) rdOut <= nextRd;
    end
  end

  AST_VALID_FOLLOWS_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> outValid); // R6

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> (!outValid && $stable(rdOut))); // R6

  AST_INACTIVE_BYTES_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.scalar) |=>
      ((rdOut ^ $past(rdOld)) & ~byteToBits($past(strobe.takeNew))) == '0); // R4

  AST_SCALAR_UPPER_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.scalar) |=>
      ((rdOut & ~lowMaskOf($past(strobe.width))) ==
       (($past(strobe.signExt) &&
         (|(rdOut & (lowMaskOf($past(strobe.width)) ^
                     (lowMaskOf($past(strobe.width)) >> 1)))))
        ? ~lowMaskOf($past(strobe.width)) : 64'd0))); // R5

endmodule

// File: rtl/simd_elw_adder.sv
module simd_elw_adder
  import elw_pkg::*;
#(
  parameter int VL_W = 7
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [1:0]      widthSel,
  input  logic            narrowXlen,
  input  logic            scalarOp,
  input  logic            signExt,
  input  logic [VL_W-1:0] vl,
  input  logic [63:0]     rs1,
  input  logic [63:0]     rs2,
  input  logic [63:0]     rdOld,
  output logic            outValid,
  output logic [63:0]     rdOut
);

  elwStrobe_t strobe;

  elw_ctrl #(.VL_W(VL_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .widthSel  (widthSel),
    .narrowXlen(narrowXlen),
    .scalarOp  (scalarOp),
    .signExt   (signExt),
    .vl        (vl),
    .strobe    (strobe)
  );

  elw_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .rs1     (rs1),
    .rs2     (rs2),
    .rdOld   (rdOld),
    .outValid(outValid),
    .rdOut   (rdOut)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |=> (!outValid && rdOut == '0)); // R7

endmodule

// File: tb/simd_elw_adder_bench.sv
`timescale 1ns/1ps
module simd_elw_adder_bench;

  localparam int VL_W = 7;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            inValid = 1'b0;
  logic [1:0]      widthSel = '0;
  logic            narrowXlen = 1'b0;
  logic            scalarOp = 1'b0;
  logic            signExt = 1'b0;
  logic [VL_W-1:0] vl = '0;
  logic [63:0]     rs1 = '0, rs2 = '0, rdOld = '0;
  logic            outValid;
  logic [63:0]     rdOut;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  simd_elw_adder #(.VL_W(VL_W)) u_simd_elw_adder (
    .clk(clk), .rstN(rstN), .inValid(inValid), .widthSel(widthSel),
    .narrowXlen(narrowXlen), .scalarOp(scalarOp), .signExt(signExt),
    .vl(vl), .rs1(rs1), .rs2(rs2), .rdOld(rdOld),
    .outValid(outValid), .rdOut(rdOut)
  );

  typedef struct packed {
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] old;
    logic [6:0]  vlen;
    logic [1:0]  sel;
    logic        x32;
    logic        scl;
    logic        sx;
    logic [3:0]  req;
    logic [63:0] exp;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    // R3: 8-bit lanes, vl=3, upper bytes kept
    '{64'h0102030405060708, 64'h10101010101010FF, 64'hAAAAAAAAAAAAAAAA, 7'd3, 2'b11, 1'b0, 1'b0, 1'b0, 4'd3, 64'hAAAAAAAAAA161707},
    // R1: narrow default halved gives 16-bit lanes
    '{64'h000000000001FFFF, 64'h0000000000010001, 64'h123456789ABCDEF0, 7'd2, 2'b01, 1'b1, 1'b0, 1'b0, 4'd1, 64'h1234567800020000},
    // R5: scalar 8-bit sign extend, vl ignored
    '{64'h123456789ABCDE70, 64'hFFFFFFFFFFFFFF20, 64'h0,               7'd0, 2'b11, 1'b0, 1'b1, 1'b1, 4'd5, 64'hFFFFFFFFFFFFFF90},
    // R5: scalar 8-bit zero extend
    '{64'h123456789ABCDE70, 64'hFFFFFFFFFFFFFF20, 64'h0,               7'd0, 2'b11, 1'b0, 1'b1, 1'b0, 4'd5, 64'h0000000000000090},
    // R4: vl=0 keeps the old value
    '{64'h1,                64'h2,                64'h5555555555555555, 7'd0, 2'b00, 1'b0, 1'b0, 1'b0, 4'd4, 64'h5555555555555555},
    // R1: doubled 64 clamps to 64, long vl
    '{64'hFFFFFFFFFFFFFFFF, 64'h1,                64'h7,               7'd5, 2'b10, 1'b0, 1'b0, 1'b0, 4'd1, 64'h0},
    // R2: 32-bit lane wraps, no carry into lane 1
    '{64'h00000001FFFFFFFF, 64'h0000000100000001, 64'hDEADBEEF00000000, 7'd1, 2'b00, 1'b1, 1'b0, 1'b0, 4'd2, 64'hDEADBEEF00000000},
    // R8: scalar 64-bit plain sum
    '{64'h7FFFFFFFFFFFFFFF, 64'h1,                64'h0,               7'd0, 2'b00, 1'b0, 1'b1, 1'b1, 4'd8, 64'h8000000000000000},
    // R3: vl beyond lane count, all bytes wrap
    '{64'hFFFFFFFFFFFFFFFF, 64'h0101010101010101, 64'h0,               7'd100, 2'b11, 1'b0, 1'b0, 1'b0, 4'd3, 64'h0},
    // R5: scalar 16-bit zero extend in narrow mode
    '{64'hFFFFFFFFFFFF8000, 64'h0000000000000001, 64'h0,               7'd0, 2'b01, 1'b1, 1'b1, 1'b0, 4'd5, 64'h0000000000008001},
    // R5: scalar 32-bit sign extend in narrow mode, rdOld ignored
    '{64'h0000000080000000, 64'h0,                64'hFFFFFFFFFFFFFFFF, 7'd7, 2'b00, 1'b1, 1'b1, 1'b1, 4'd5, 64'hFFFFFFFF80000000},
    // R2: 32-bit lanes from halved 64 default
    '{64'h00000001FFFFFFFF, 64'h0000000100000001, 64'h0,               7'd2, 2'b01, 1'b0, 1'b0, 1'b0, 4'd2, 64'h0000000200000000}
  };

  // Per-lane reference model built from the requirements
  function automatic logic [63:0] refRd(input logic [63:0] a, input logic [63:0] b,
                                        input logic [63:0] old, input int vlv,
                                        input logic [1:0] sel, input logic x32,
                                        input logic scl, input logic sx);
    int def;
    int w;
    logic [63:0] m;
    logic [63:0] s;
    logic [63:0] res;
    logic [63:0] lane;
    def = x32 ? 32 : 64;
    case (sel)
      2'b00:   w = def;
      2'b01:   w = def / 2;
      2'b10:   w = (def * 2 > 64) ? 64 : def * 2;
      default: w = 8;
    endcase
    m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    if (scl) begin
      s = (a + b) & m;
      if (sx && s[w-1]) s = s | ~m;
      return s;
    end
    res = old;
    for (int i = 0; i < 64 / w; i++) begin
      if (i < vlv) begin
        lane = ((a >> (i * w)) + (b >> (i * w))) & m;
        res  = (res & ~(m << (i * w))) | (lane << (i * w));
      end
    end
    return res;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runOp(input logic [63:0] a, input logic [63:0] b, input logic [63:0] old,
                       input logic [6:0] vlen, input logic [1:0] sel, input logic x32,
                       input logic scl, input logic sx);
    @(negedge clk);
    rs1 = a; rs2 = b; rdOld = old; vl = vlen; widthSel = sel;
    narrowXlen = x32; scalarOp = scl; signExt = sx; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  logic [63:0] seed = 64'h9E3779B97F4A7C15;
  function automatic logic [63:0] nextRand(input logic [63:0] x);
    logic [63:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 7);
    y = y ^ (y << 17);
    return y;
  endfunction

  initial begin
    logic [63:0] held;
    logic [63:0] ra, rb, ro;
    // R7: reset state
    repeat (3) @(negedge clk);
    check("R7 rdOut in reset", rdOut, 64'h0);
    check("R7 outValid in reset", {63'd0, outValid}, 64'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Table walk: hand values and model must both agree
    for (int i = 0; i < NVEC; i++) begin
      runOp(VECS[i].a, VECS[i].b, VECS[i].old, VECS[i].vlen, VECS[i].sel,
            VECS[i].x32, VECS[i].scl, VECS[i].sx);
      check($sformatf("R%0d table %0d", VECS[i].req, i), rdOut, VECS[i].exp);
      check($sformatf("R%0d table %0d model", VECS[i].req, i),
            rdOut, refRd(VECS[i].a, VECS[i].b, VECS[i].old, int'(VECS[i].vlen),
                         VECS[i].sel, VECS[i].x32, VECS[i].scl, VECS[i].sx));
      check("R6 outValid after strobe", {63'd0, outValid}, 64'd1);
    end

    // R6: idle cycles keep outValid low and rdOut held
    held = rdOut;
    @(negedge clk);
    check("R6 outValid idle", {63'd0, outValid}, 64'd0);
    rs1 = '1; rs2 = '1; rdOld = '1;
    @(negedge clk);
    check("R6 rdOut held", rdOut, held);

    // Sweep: R1 R2 R3 R4 R5 R8 over all widths, modes and vl 0..9
    for (int sel = 0; sel < 4; sel++) begin
      for (int x = 0; x < 2; x++) begin
        for (int sc = 0; sc < 2; sc++) begin
          for (int sx = 0; sx < 2; sx++) begin
            for (int v = 0; v < 10; v++) begin
              seed = nextRand(seed); ra = seed;
              seed = nextRand(seed); rb = seed;
              seed = nextRand(seed); ro = seed;
              runOp(ra, rb, ro, 7'(v), 2'(sel), 1'(x), 1'(sc), 1'(sx));
              check($sformatf("R1/R3 sweep sel=%0d x32=%0d scalar=%0d sx=%0d vl=%0d",
                              sel, x, sc, sx, v),
                    rdOut, refRd(ra, rb, ro, v, 2'(sel), 1'(x), 1'(sc), 1'(sx)));
            end
          end
        end
      end
    end

    // R7: reset mid-run clears the result
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R7 rdOut after reset", rdOut, 64'h0);
    check("R7 outValid after reset", {63'd0, outValid}, 64'd0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule